// File: doc/BRIEF.md
# Flow-Through Burst SRAM Cycle Controller

This block is a synthesizable model of a single-ported synchronous burst SRAM with a common data path and flow-through reads. It is organised as four lanes, and each lane holds eight data bits and one parity bit, which gives a 36-bit word. An access begins on either of two address strobes, a processor strobe or a controller strobe, and only when all three chip selects are active. A two-bit wrap-around offset counter then walks the word address through a four-beat burst. The counter follows either an interleaved order or a linear order.

Writes are qualified by a global write, a byte-write enable and four byte selects, all active low. The first-cycle behaviour depends on the strobe that opened the access. A processor-started access always reads in its first cycle. A controller-started access can write at once. Read data comes straight from the array at the registered address. The data bus is modelled as a `rdata` bus plus an enable flag rather than a tristate pin.

A sleep input drops any open burst, ignores all other inputs and turns the outputs off, and the stored data is kept. After sleep falls, a two-cycle recovery window keeps the array blocked. Any strobe or chip-select activity inside that window is flagged.

Top module: `fbsram_core`

## Requirements
- R1: An access begins only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 at the clock edge where a strobe is recognised. A recognised strobe with any select inactive ends an open burst, and the outputs stay disabled until a new access begins.
- R2: `proc_stb_n` is ignored while `sel_a_n`=1. In that case an open burst continues as though no strobe were present. When both strobes are low and `sel_a_n`=0, only the processor strobe is recognised.
- R3: An access opened by the processor strobe is a read in its first cycle, whatever the write inputs are. Write inputs on the following edge write the current burst address.
- R4: An access opened by the controller strobe while the processor strobe is not recognised writes in that same edge if the write inputs call for a write. Otherwise it is a read.
- R5: `gwr_n`=0 writes all four lanes, whatever `bwr_en_n` and `bsel_n` are.
- R6: With `gwr_n`=1 and `bwr_en_n`=0, `bsel_n[n]`=0 writes data bits [8n+7:8n] and parity bit 32+n. The other bits of the word keep their value.
- R7: With `gwr_n`=1, the cycle is a read and the array is unchanged if `bwr_en_n`=1, or if all four `bsel_n` bits are 1.
- R8: After the edge that samples a read address, the word at that address is on `rdata` in the same cycle, with no further register stage.
- R9: In a continued burst, `adv_n`=0 advances a two-bit offset k from the start offset s. The low two address bits are s XOR k when `burst_ilv`=1 at burst start, and (s+k) mod 4 when it is 0. The upper address bits are fixed, the order wraps after four beats, and `adv_n`=1 holds the address.
- R10: `rdata_en` is 1 only during a read cycle of an open burst with `oe_n`=0. It follows `oe_n` without waiting for a clock, and it is 0 in any write cycle whatever `oe_n` is. `rdata` is all zeros whenever `rdata_en` is 0.
- R11: While `sleep_i`=1, `rdata_en` is 0 at once, all other inputs are ignored and no write happens, and an open burst is dropped. The array contents are kept.
- R12: For the two clock edges after `sleep_i` falls, no access begins. Any strobe or active chip select at those edges raises `proto_err` for one cycle. `proto_err` stays 0 outside that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_i | input | 1 | Sleep request, active high |
| sel_a_n | input | 1 | Chip select A, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| burst_ilv | input | 1 | Burst order at start: 1 interleaved, 0 linear |
| addr | input | AW | Word address |
| gwr_n | input | 1 | Global write, active low |
| bwr_en_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 4 | Byte selects, active low, one per lane |
| wdata | input | 36 | Write data: lane n data at [8n+7:8n], parity at bit 32+n |
| oe_n | input | 1 | Output enable, active low, not clocked |
| rdata | output | 36 | Read data, zero when disabled |
| rdata_en | output | 1 | High while `rdata` is driven |
| proto_err | output | 1 | One-cycle flag for activity in the sleep recovery window |

## Verification
The hardest situation to reach from the ports is the sleep recovery window. It lasts only two edges, it needs an open burst to be cut off first, and a stray strobe inside it must be both flagged and refused. The stimulus opens a read burst and raises sleep in the middle of a cycle, and it attempts a global write during sleep. It then keeps every select quiet for the first recovery edge and drives a full read at the second. After that it reads the target words back to show that the write attempt and the refused read left the array untouched. The burst order is swept over both modes, all four start offsets, a wrap beat and a hold beat. The byte-write logic is swept over all sixteen select patterns against a known background word.

// File: rtl/fbsram_pkg.sv
// Package: shared word layout and cycle encoding for the burst SRAM model.
// Assumes four lanes of eight data bits plus one parity bit per lane; the
// parity bits sit above all data bits, lane n parity at bit LANES*LANE_W+n.
package fbsram_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * (LANE_W + 1);

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;

    // Expand a per-lane enable into a per-bit mask of the stored word.
    function automatic logic [WORD_W-1:0] lane_bits(input logic [LANES-1:0] m);
        logic [WORD_W-1:0] r;
        r = '0;
        for (int n = 0; n < LANES; n++) begin
            r[n*LANE_W +: LANE_W] = {LANE_W{m[n]}};
            r[LANES*LANE_W + n]   = m[n];
        end
        return r;
    endfunction
endpackage

// File: rtl/fbsram_wr_decode.sv
// Module: write qualifier. Turns global write, byte-write enable and byte
// selects (all active low) into per-lane write enables. Purely combinational;
// assumes the caller decides whether the cycle may write at all.
module fbsram_wr_decode
    import fbsram_pkg::*;
(
    input  logic             gwr_n,
    input  logic             bwr_en_n,
    input  logic [LANES-1:0] bsel_n,
    output logic [LANES-1:0] lane_we,
    output logic             any_we
);
    // Global write wins; otherwise selects count only under the byte enable.
    always_comb begin
        if (!gwr_n)
            lane_we = '1;
        else if (!bwr_en_n)
            lane_we = ~bsel_n;
        else
            lane_we = '0;
        any_we = |lane_we;
    end
endmodule

// File: rtl/fbsram_burst_ctr.sv
// Module: burst address generator. Captures a start address on load and
// walks the low two bits with a wrapping offset in interleaved or linear
// order, the order being latched at load. Assumes AW >= 3.
module fbsram_burst_ctr #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          ilv_i,
    input  logic [AW-1:0] base_i,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] nxt_addr
);
    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic          ilv_q;

    function automatic logic [1:0] seq_off(input logic [1:0] b, input logic [1:0] c,
                                           input logic il);
        return il ? (b ^ c) : (b + c);
    endfunction

    // Capture start address and order, or advance the offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            ilv_q  <= 1'b0;
        end else if (load) begin
            base_q <= base_i;
            cnt_q  <= '0;
            ilv_q  <= ilv_i;
        end else if (step) begin
            cnt_q  <= cnt_q + 2'd1;
        end
    end

    // Current address and the address the next edge will use.
    always_comb begin
        cur_addr = {base_q[AW-1:2], seq_off(base_q[1:0], cnt_q, ilv_q)};
        if (load)
            nxt_addr = base_i;
        else if (step)
            nxt_addr = {base_q[AW-1:2], seq_off(base_q[1:0], cnt_q + 2'd1, ilv_q)};
        else
            nxt_addr = cur_addr;
    end

    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cur_addr == $past(base_i));                                   // R9
    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(cur_addr));                               // R9
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step) |=> cur_addr[AW-1:2] == $past(cur_addr[AW-1:2]));      // R9
endmodule

// File: rtl/fbsram_sleep_ctl.sv
// Module: sleep and recovery control. Blocks the array while sleep is high
// and for REC_CYC edges after it falls, and flags any strobe or chip-select
// activity seen at those recovery edges with a one-cycle pulse.
module fbsram_sleep_ctl #(
    parameter int REC_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    input  logic activity_i,
    output logic blocked,
    output logic proto_err
);
    localparam int RW = $clog2(REC_CYC + 1);

    logic [RW-1:0] rec_q;

    // Reload the recovery count during sleep, count it down afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rec_q <= '0;
        else if (sleep_i)
            rec_q <= RW'(REC_CYC);
        else if (rec_q != '0)
            rec_q <= rec_q - RW'(1);
    end

    // Register a violation seen inside the recovery window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            proto_err <= 1'b0;
        else
            proto_err <= !sleep_i && (rec_q != '0) && activity_i;
    end

    assign blocked = sleep_i || (rec_q != '0);

    AST_ERR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(rec_q != '0));                                     // R12
endmodule

// File: rtl/fbsram_core.sv
// Module: top of the flow-through burst SRAM model. Recognises strobes under
// the chip selects, sequences bursts, qualifies writes by start strobe and
// drives the read bus straight from the array. Assumes the array needs no
// reset (contents are undefined until written) and oe_n is unclocked.
module fbsram_core
    import fbsram_pkg::*;
#(
    parameter int AW      = 6,
    parameter int REC_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              proc_stb_n,
    input  logic              ctrl_stb_n,
    input  logic              adv_n,
    input  logic              burst_ilv,
    input  logic [AW-1:0]     addr,
    input  logic              gwr_n,
    input  logic              bwr_en_n,
    input  logic [LANES-1:0]  bsel_n,
    input  logic [WORD_W-1:0] wdata,
    input  logic              oe_n,
    output logic [WORD_W-1:0] rdata,
    output logic              rdata_en,
    output logic              proto_err
);
    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem [DEPTH];
    cyc_e              cyc_q;
    logic [LANES-1:0]  lane_we;
    logic              any_we;
    logic [AW-1:0]     cur_addr, nxt_addr;
    logic              blocked, awake, sel_ok, proc_go, ctrl_go, any_go;
    logic              begin_acc, desel, cont, step, wr_now, activity;
    logic [WORD_W-1:0] bit_mask;

    fbsram_wr_decode u_wr_decode (
        .gwr_n    (gwr_n),
        .bwr_en_n (bwr_en_n),
        .bsel_n   (bsel_n),
        .lane_we  (lane_we),
        .any_we   (any_we)
    );

    fbsram_burst_ctr #(.AW(AW)) u_burst_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (begin_acc),
        .step     (step),
        .ilv_i    (burst_ilv),
        .base_i   (addr),
        .cur_addr (cur_addr),
        .nxt_addr (nxt_addr)
    );

    fbsram_sleep_ctl #(.REC_CYC(REC_CYC)) u_sleep_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_i    (sleep_i),
        .activity_i (activity),
        .blocked    (blocked),
        .proto_err  (proto_err)
    );

    // Strobe recognition, burst continuation and write qualification.
    always_comb begin
        awake     = !blocked;
        sel_ok    = !sel_a_n && sel_b && !sel_c_n;
        proc_go   = !proc_stb_n && !sel_a_n;
        ctrl_go   = !proc_go && !ctrl_stb_n;
        any_go    = proc_go || ctrl_go;
        begin_acc = awake && any_go && sel_ok;
        desel     = awake && any_go && !sel_ok;
        cont      = awake && !any_go && (cyc_q != CYC_IDLE);
        step      = cont && !adv_n;
        wr_now    = awake && any_we && ((ctrl_go && sel_ok) || cont);
        activity  = !proc_stb_n || !ctrl_stb_n || !sel_a_n || sel_b || !sel_c_n;
        bit_mask  = lane_bits(lane_we);
    end

    // Cycle type of the access now on the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cyc_q <= CYC_IDLE;
        else if (!awake || desel)
            cyc_q <= CYC_IDLE;
        else if (begin_acc)
            cyc_q <= (ctrl_go && any_we) ? CYC_WRITE : CYC_READ;
        else if (cont)
            cyc_q <= any_we ? CYC_WRITE : CYC_READ;
    end

    // Lane-masked array write at the address used by this edge.
    always_ff @(posedge clk) begin
        if (rst_n && wr_now)
            mem[nxt_addr] <= (mem[nxt_addr] & ~bit_mask) | (wdata & bit_mask);
    end

    // Flow-through read path, gated by cycle type, oe_n and sleep.
    always_comb begin
        rdata_en = (cyc_q == CYC_READ) && !oe_n && !sleep_i;
        rdata    = rdata_en ? mem[cur_addr] : '0;
    end

    AST_PROC_FIRST_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (begin_acc && proc_go) |=> (cyc_q == CYC_READ));                       // R3
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        desel |=> !rdata_en);                                                  // R1
    AST_SLEEP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (cyc_q == CYC_IDLE));                                      // R11
    AST_BLOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && cyc_q == CYC_IDLE) |=> (cyc_q == CYC_IDLE));               // R12
endmodule

// File: tb/fbsram_core_bench.sv
module fbsram_core_bench;
    localparam int AW = 6;

    logic        clk = 1'b0;
    logic        rst_n, sleep_i, sel_a_n, sel_b, sel_c_n;
    logic        proc_stb_n, ctrl_stb_n, adv_n, burst_ilv;
    logic [AW-1:0] addr;
    logic        gwr_n, bwr_en_n;
    logic [3:0]  bsel_n;
    logic [35:0] wdata, rdata;
    logic        oe_n, rdata_en, proto_err;

    logic [35:0] model [64];
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fbsram_core #(.AW(AW)) u_fbsram_core (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .sel_a_n(sel_a_n),
        .sel_b(sel_b), .sel_c_n(sel_c_n), .proc_stb_n(proc_stb_n),
        .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n), .burst_ilv(burst_ilv),
        .addr(addr), .gwr_n(gwr_n), .bwr_en_n(bwr_en_n), .bsel_n(bsel_n),
        .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rdata_en(rdata_en),
        .proto_err(proto_err)
    );

    function automatic logic [35:0] pat(input int a, input int salt);
        return (36'(a) * 36'd73471 + 36'(salt) * 36'd1000003) ^ 36'h5_A5A5_A5A5;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic quiet();
        proc_stb_n = 1'b1; ctrl_stb_n = 1'b1; adv_n = 1'b1;
        gwr_n = 1'b1; bwr_en_n = 1'b1; bsel_n = 4'hF;
    endtask

    task automatic sel_on();
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    endtask

    task automatic gw_write(input int a, input logic [35:0] d);
        quiet(); ctrl_stb_n = 1'b0; addr = AW'(a); gwr_n = 1'b0; wdata = d;
        tick();
        chk(rdata_en == 1'b0, "R10 write off", 36'(rdata_en), 36'd0);
        model[a] = d;
        quiet();
    endtask

    task automatic read_chk(input int a, input string req);
        quiet(); proc_stb_n = 1'b0; addr = AW'(a);
        tick();
        chk(rdata_en && rdata == model[a], req, rdata, model[a]);
        quiet();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 36'd0, 36'd1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [35:0] p, q, msk, ex;
        rst_n = 1'b0; sleep_i = 1'b0; burst_ilv = 1'b0; addr = '0;
        wdata = '0; oe_n = 1'b0;
        sel_on(); quiet();
        repeat (3) tick();
        chk(rdata_en == 1'b0 && rdata == '0, "R10 reset", rdata, 36'd0);
        chk(proto_err == 1'b0, "R12 reset", 36'(proto_err), 36'd0);
        rst_n = 1'b1;
        tick();

        // R4 R5: fill the array with controller-started global writes
        for (int a = 0; a < 64; a++) gw_write(a, pat(a, 1));
        // R8: flow-through reads of every word
        for (int a = 0; a < 64; a++) read_chk(a, "R8 sweep");

        // R6 R7 R4: all sixteen lane patterns
        for (int m = 0; m < 16; m++) begin
            p = pat(m, 7); q = pat(m, 9);
            gw_write(5, p);
            quiet(); ctrl_stb_n = 1'b0; addr = 6'd5; bwr_en_n = 1'b0;
            bsel_n = ~4'(m); wdata = q;
            tick();
            if (m == 0)
                chk(rdata_en && rdata == p, "R7 no lanes", rdata, p);
            else
                chk(rdata_en == 1'b0, "R4 ctrl write", 36'(rdata_en), 36'd0);
            msk = '0;
            for (int n = 0; n < 4; n++)
                if (m[n]) begin
                    msk[n*8 +: 8] = 8'hFF;
                    msk[32+n] = 1'b1;
                end
            model[5] = (p & ~msk) | (q & msk);
            read_chk(5, "R6 lanes");
        end
        // R7: byte enable off
        quiet(); ctrl_stb_n = 1'b0; addr = 6'd5; bsel_n = 4'h0; wdata = pat(0, 55);
        tick();
        chk(rdata_en && rdata == model[5], "R7 enable off", rdata, model[5]);
        read_chk(5, "R7 unchanged");
        // R5: global write overrides
        quiet(); ctrl_stb_n = 1'b0; addr = 6'd6; gwr_n = 1'b0; bwr_en_n = 1'b1;
        bsel_n = 4'hF; wdata = pat(6, 77);
        tick();
        model[6] = pat(6, 77);
        read_chk(6, "R5 global");

        // R9: burst orders
        for (int il = 0; il < 2; il++)
            for (int s = 0; s < 4; s++) begin
                quiet(); burst_ilv = 1'(il); proc_stb_n = 1'b0; addr = AW'(8 + s);
                tick();
                chk(rdata == model[8+s], "R9 beat0", rdata, model[8+s]);
                burst_ilv = ~1'(il);
                ex = '0;
                for (int k = 1; k <= 5; k++) begin
                    logic [1:0] lo;
                    int kk;
                    kk = (k == 5) ? 4 : k;
                    quiet(); adv_n = (k == 5);
                    tick();
                    lo = il ? (2'(s) ^ 2'(kk)) : 2'(s + kk);
                    ex = model[8 + lo];
                    chk(rdata_en && rdata == ex, k == 5 ? "R9 hold" : "R9 beat", rdata, ex);
                end
            end
        burst_ilv = 1'b0;

        // R3: processor start with write inputs is a read, write next edge
        quiet(); proc_stb_n = 1'b0; addr = 6'd9; gwr_n = 1'b0; wdata = pat(9, 3);
        tick();
        chk(rdata_en && rdata == model[9], "R3 first read", rdata, model[9]);
        quiet(); gwr_n = 1'b0; wdata = pat(9, 4);
        tick();
        chk(rdata_en == 1'b0, "R10 write ignores oe", 36'(rdata_en), 36'd0);
        model[9] = pat(9, 4);
        quiet();
        tick();
        chk(rdata_en && rdata == model[9], "R3 second edge write", rdata, model[9]);

        // R2: priority and gating of the processor strobe
        quiet(); proc_stb_n = 1'b0; ctrl_stb_n = 1'b0; addr = 6'd10; gwr_n = 1'b0;
        wdata = pat(10, 5);
        tick();
        chk(rdata_en && rdata == model[10], "R2 priority", rdata, model[10]);
        read_chk(10, "R2 no write");
        read_chk(12, "R2 setup");
        sel_a_n = 1'b1; proc_stb_n = 1'b0; adv_n = 1'b0; addr = 6'd40;
        tick();
        chk(rdata == model[13], "R2 gated strobe", rdata, model[13]);
        sel_on(); quiet();

        // R1: deselect
        quiet(); ctrl_stb_n = 1'b0; sel_b = 1'b0; addr = 6'd20;
        tick();
        chk(rdata_en == 1'b0, "R1 deselect", 36'(rdata_en), 36'd0);
        quiet(); adv_n = 1'b0;
        tick();
        chk(rdata_en == 1'b0, "R1 burst ended", 36'(rdata_en), 36'd0);
        sel_on();
        quiet(); proc_stb_n = 1'b0; sel_c_n = 1'b1; addr = 6'd21;
        tick();
        chk(rdata_en == 1'b0, "R1 select c", 36'(rdata_en), 36'd0);
        sel_on();

        // R10: unclocked output enable
        quiet(); oe_n = 1'b1; proc_stb_n = 1'b0; addr = 6'd22;
        tick();
        chk(rdata_en == 1'b0 && rdata == '0, "R10 oe high", rdata, 36'd0);
        oe_n = 1'b0; #1;
        chk(rdata_en && rdata == model[22], "R10 oe low", rdata, model[22]);
        quiet();

        // R11 R12: sleep and recovery
        read_chk(20, "R8 pre-sleep");
        sleep_i = 1'b1; #1;
        chk(rdata_en == 1'b0, "R11 outputs off", 36'(rdata_en), 36'd0);
        ctrl_stb_n = 1'b0; gwr_n = 1'b0; addr = 6'd21; wdata = pat(21, 99);
        tick(); tick();
        quiet(); sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1;
        sleep_i = 1'b0;
        tick();
        chk(proto_err == 1'b0, "R12 quiet window", 36'(proto_err), 36'd0);
        chk(rdata_en == 1'b0, "R11 burst dropped", 36'(rdata_en), 36'd0);
        sel_on(); proc_stb_n = 1'b0; addr = 6'd21;
        tick();
        chk(proto_err == 1'b1, "R12 flag", 36'(proto_err), 36'd1);
        chk(rdata_en == 1'b0, "R12 blocked", 36'(rdata_en), 36'd0);
        quiet();
        tick();
        chk(proto_err == 1'b0, "R12 pulse ends", 36'(proto_err), 36'd0);
        read_chk(21, "R11 contents kept");
        read_chk(20, "R11 contents kept");
        // clean recovery: two quiet edges, then an access works
        sleep_i = 1'b1;
        tick();
        sleep_i = 1'b0; sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1;
        tick(); tick();
        chk(proto_err == 1'b0, "R12 clean", 36'(proto_err), 36'd0);
        sel_on();
        read_chk(30, "R12 after recovery");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule